// File: doc/BRIEF.md
# Three-level PWM input qualifier

This block turns a three-level PWM command into one clean digital state: HIGH, LOW or TRISTATE. An analog front end outside the block supplies two comparator flags. `aboveHigh` is set while the input is above the upper logic threshold. `belowLow` is set while it is below the lower logic threshold. When neither flag is set, the input sits in the middle window. A floating pin biases itself into that window, so an undriven input looks the same as a mid-level command.

The filter is asymmetric. A middle-window level is reported as TRISTATE only after it has lasted a long holdoff of `HOLDOFF_CYCLES` consecutive samples, so short mid-window glitches are ignored. A logic level is reported after a short run of `EXIT_CYCLES` consecutive samples. That holds when leaving TRISTATE, and also on a direct HIGH/LOW swing that never passes through the window.

The reported state is a registered 2-bit code. A one-cycle strobe comes with every change of that code. Downstream gate-drive logic uses the state to choose between driving one switch, driving the other, or releasing both.

Top module: `pwm3_qualifier`

## Requirements
- R1: The state encoding is 2'b00 for LOW, 2'b01 for HIGH and 2'b10 for TRISTATE; 2'b11 never appears. A synchronous reset (active-high `rst`) sets the state to TRISTATE with `stateChanged` low.
- R2: Each clock samples one input class: `aboveHigh`=1 with `belowLow`=0 is HIGH, `belowLow`=1 with `aboveHigh`=0 is LOW, and both flags at 0 is the middle window.
- R3: After HOLDOFF_CYCLES consecutive middle-window samples, the state becomes TRISTATE at the clock edge of the last of them. This holds whether the previous state was HIGH or LOW, and it covers an undriven input.
- R4: Any HIGH, LOW or contradictory sample restarts the holdoff count. A middle-window run shorter than HOLDOFF_CYCLES therefore leaves the state unchanged, however often such runs repeat.
- R5: After EXIT_CYCLES consecutive samples of one logic level, the state becomes that level at the clock edge of the last of them.
- R6: A direct LOW-to-HIGH or HIGH-to-LOW swing is accepted after EXIT_CYCLES samples of the new level, with no holdoff.
- R7: `stateChanged` is high for exactly the one cycle in which a new state value first appears, and it is low at all other times.
- R8: A sample with both flags set changes no state. It clears both the holdoff count and the logic-level run count.
- R9: A logic-level run shorter than EXIT_CYCLES, whether broken by a middle-window sample or by the other level, leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| aboveHigh | input | 1 | Comparator flag: input above upper logic threshold |
| belowLow | input | 1 | Comparator flag: input below lower logic threshold |
| level | output | 2 | Qualified state: 00 LOW, 01 HIGH, 10 TRISTATE |
| stateChanged | output | 1 | One-cycle strobe on every change of `level` |

## Verification
A wrong holdoff count shows at the ports as a TRISTATE that arrives early, late or not at all after a long mid-window run. It also shows as a TRISTATE caused by a short glitch train, and it is visible in the exact cycle that should have ended the run. A wrong level-run count or a stale run tag shows as a logic level accepted one sample too soon or too late after a direct swing or a broken run. A wrong strobe shows the same cycle as a `stateChanged` pulse that does not match a change of `level`. The stimulus ends each run exactly on a boundary cycle, so an off-by-one error in either counter changes the sampled value at once.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_TRI  = 2'b10
  } level_e;

  // strobes from the state control to the run counters
  typedef struct packed {
    logic   midInc;      // extend the middle-window run
    logic   midClr;      // restart the middle-window run
    logic   lvlInc;      // extend the current logic-level run
    logic   lvlRestart;  // start a new logic-level run tagged lvlTag
    logic   lvlClr;      // drop the logic-level run
    level_e lvlTag;
  } cnt_ctrl_s;

endpackage

// File: rtl/pwm3_run_counters.sv
module pwm3_run_counters
  import pwm3_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 78,
  parameter int EXIT_CYCLES    = 9
) (
  input  logic      clk,
  input  logic      rst,
  input  cnt_ctrl_s ctrl,
  output logic      midAtLimit,
  output logic      lvlAtLimit,
  output logic      lvlActive,
  output level_e    lvlLast
);

  localparam int MID_W = $clog2(HOLDOFF_CYCLES + 1);
  localparam int LVL_W = $clog2(EXIT_CYCLES + 1);
  localparam logic [MID_W-1:0] MID_MAX  = MID_W'(HOLDOFF_CYCLES - 1);
  localparam logic [LVL_W-1:0] LVL_MAX  = LVL_W'(EXIT_CYCLES);
  localparam logic [LVL_W-1:0] LVL_EDGE = LVL_W'(EXIT_CYCLES - 1);

  logic [MID_W-1:0] midCnt;
  logic [LVL_W-1:0] lvlCnt;

  always_ff @(posedge clk) begin
    if (rst || ctrl.midClr) begin
      midCnt <= '0;
    end else if (ctrl.midInc && (midCnt != MID_MAX)) begin
      midCnt <= midCnt + MID_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.lvlClr) begin
      lvlCnt  <= '0;
      lvlLast <= LVL_LOW;
    end else if (ctrl.lvlRestart) begin
      lvlCnt  <= LVL_W'(1);
      lvlLast <= ctrl.lvlTag;
    end else if (ctrl.lvlInc && (lvlCnt != LVL_MAX)) begin
      lvlCnt <= lvlCnt + LVL_W'(1);
    end
  end

  assign midAtLimit = (midCnt == MID_MAX);
  assign lvlAtLimit = (lvlCnt >= LVL_EDGE);
  assign lvlActive  = (lvlCnt != '0);

  // R3: the holdoff run never counts past its acceptance point
  assert_holdoff_bound_R3: assert property (@(posedge clk) disable iff (rst)
    midCnt <= MID_MAX);

  // R5: the level run saturates at the exit length
  assert_exit_bound_R5: assert property (@(posedge clk) disable iff (rst)
    lvlCnt <= LVL_MAX);

  // R8: a contradictory sample leaves no run in progress
  assert_both_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl.midClr && ctrl.lvlClr) |=> (midCnt == '0) && (lvlCnt == '0));

endmodule

// File: rtl/pwm3_state_ctl.sv
module pwm3_state_ctl
  import pwm3_pkg::*;
#(
  parameter int EXIT_CYCLES = 9
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      aboveHigh,
  input  logic      belowLow,
  input  logic      midAtLimit,
  input  logic      lvlAtLimit,
  input  logic      lvlActive,
  input  level_e    lvlLast,
  output cnt_ctrl_s ctrl,
  output level_e    level,
  output logic      stateChanged
);

  level_e nextLevel;
  level_e tag;
  logic   sameRun;
  logic   armed;

  always_comb begin
    ctrl      = '0;
    nextLevel = level;
    tag       = aboveHigh ? LVL_HIGH : LVL_LOW;
    sameRun   = lvlActive && (lvlLast == tag);
    unique case ({aboveHigh, belowLow})
      2'b00: begin
        ctrl.midInc = 1'b1;
        ctrl.lvlClr = 1'b1;
        if (midAtLimit) nextLevel = LVL_TRI;
      end
      2'b10, 2'b01: begin
        ctrl.midClr = 1'b1;
        ctrl.lvlTag = tag;
        if (sameRun) ctrl.lvlInc = 1'b1;
        else         ctrl.lvlRestart = 1'b1;
        if ((EXIT_CYCLES == 1) || (sameRun && lvlAtLimit)) nextLevel = tag;
      end
      default: begin
        ctrl.midClr = 1'b1;
        ctrl.lvlClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level        <= LVL_TRI;
      stateChanged <= 1'b0;
      armed        <= 1'b0;
    end else begin
      level        <= nextLevel;
      stateChanged <= (nextLevel != level);
      armed        <= 1'b1;
    end
  end

  // R1: only the three legal codes appear
  assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    level != 2'b11);

  // R7: a strobe always marks a change, and a change always carries a strobe
  assert_strobe_marks_change_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    stateChanged |-> (level != $past(level)));
  assert_change_has_strobe_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (level != $past(level)) |-> stateChanged);

  // R3: TRISTATE is entered only from a middle-window sample
  assert_tri_from_mid_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (level == LVL_TRI && $past(level) != LVL_TRI) |-> $past(!aboveHigh && !belowLow));

  // R2: a logic level is entered only from a matching sample
  assert_high_from_flag_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (level == LVL_HIGH && $past(level) != LVL_HIGH) |-> $past(aboveHigh && !belowLow));
  assert_low_from_flag_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (level == LVL_LOW && $past(level) != LVL_LOW) |-> $past(belowLow && !aboveHigh));

  // R8: a contradictory sample never moves the state
  assert_both_hold_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(aboveHigh && belowLow) |-> (level == $past(level)));

endmodule

// File: rtl/pwm3_qualifier.sv
module pwm3_qualifier
  import pwm3_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 78,
  parameter int EXIT_CYCLES    = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       aboveHigh,
  input  logic       belowLow,
  output logic [1:0] level,
  output logic       stateChanged
);

  cnt_ctrl_s ctrl;
  logic      midAtLimit;
  logic      lvlAtLimit;
  logic      lvlActive;
  level_e    lvlLast;
  level_e    stateLevel;

  pwm3_run_counters #(
    .HOLDOFF_CYCLES(HOLDOFF_CYCLES),
    .EXIT_CYCLES   (EXIT_CYCLES)
  ) u_counters (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .midAtLimit(midAtLimit),
    .lvlAtLimit(lvlAtLimit),
    .lvlActive (lvlActive),
    .lvlLast   (lvlLast)
  );

  pwm3_state_ctl #(
    .EXIT_CYCLES(EXIT_CYCLES)
  ) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .aboveHigh   (aboveHigh),
    .belowLow    (belowLow),
    .midAtLimit  (midAtLimit),
    .lvlAtLimit  (lvlAtLimit),
    .lvlActive   (lvlActive),
    .lvlLast     (lvlLast),
    .ctrl        (ctrl),
    .level       (stateLevel),
    .stateChanged(stateChanged)
  );

  assign level = stateLevel;

endmodule

// File: tb/sim_pwm3_qualifier.sv
module sim_pwm3_qualifier;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       aboveHigh = 1'b1;
  logic       belowLow = 1'b0;
  logic [1:0] level;
  logic       stateChanged;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  localparam logic [1:0] EL = 2'b00;
  localparam logic [1:0] EH = 2'b01;
  localparam logic [1:0] ET = 2'b10;

  always #2 clk = ~clk;

  pwm3_qualifier #(.HOLDOFF_CYCLES(78), .EXIT_CYCLES(9)) u0 (
    .clk(clk), .rst(rst), .aboveHigh(aboveHigh), .belowLow(belowLow),
    .level(level), .stateChanged(stateChanged)
  );

  // {aboveHigh, belowLow, cycles[7:0], expLevel[1:0], expStrobe, req[3:0]}
  localparam int NVEC = 20;
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {2'b10, 8'd8,   ET, 1'b0, 4'd9},  // R9 short high run from reset
    {2'b10, 8'd1,   EH, 1'b1, 4'd5},  // R5 ninth high sample
    {2'b10, 8'd1,   EH, 1'b0, 4'd7},  // R7 strobe lasts one cycle
    {2'b00, 8'd77,  EH, 1'b0, 4'd4},  // R4 one short of holdoff
    {2'b10, 8'd1,   EH, 1'b0, 4'd4},  // R4 high breaks the run
    {2'b00, 8'd77,  EH, 1'b0, 4'd4},  // R4 count restarted
    {2'b00, 8'd1,   ET, 1'b1, 4'd3},  // R3 78th mid sample from HIGH
    {2'b00, 8'd5,   ET, 1'b0, 4'd7},  // R7 no further strobe
    {2'b01, 8'd9,   EL, 1'b1, 4'd5},  // R5 exit to LOW
    {2'b10, 8'd9,   EH, 1'b1, 4'd6},  // R6 direct LOW to HIGH
    {2'b01, 8'd5,   EH, 1'b0, 4'd9},  // R9 short low run
    {2'b00, 8'd3,   EH, 1'b0, 4'd9},  // R9 mid breaks it
    {2'b01, 8'd9,   EL, 1'b1, 4'd2},  // R2 low flag alone means LOW
    {2'b11, 8'd100, EL, 1'b0, 4'd8},  // R8 both flags hold LOW
    {2'b00, 8'd78,  ET, 1'b1, 4'd3},  // R3 full holdoff from LOW
    {2'b11, 8'd100, ET, 1'b0, 4'd8},  // R8 both flags hold TRISTATE
    {2'b01, 8'd8,   ET, 1'b0, 4'd9},  // R9 eight low samples
    {2'b11, 8'd1,   ET, 1'b0, 4'd8},  // R8 contradictory sample
    {2'b01, 8'd8,   ET, 1'b0, 4'd8},  // R8 run was cleared
    {2'b01, 8'd1,   EL, 1'b1, 4'd5}   // R5 ninth sample of new run
  };

  task automatic check(input string tag, input logic [1:0] expL, input logic expS);
    compared++;
    if (level !== expL || stateChanged !== expS) begin
      mismatched++;
      $display("FAIL %s: level=%b strobe=%b expected level=%b strobe=%b at %0t",
               tag, level, stateChanged, expL, expS, $time);
    end
  endtask

  // drive inputs at a falling edge, hold them for n rising edges
  task automatic drive(input logic ah, input logic bl, input int n);
    aboveHigh = ah;
    belowLow  = bl;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish (R1 sequence incomplete)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", ET, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][16], VEC[i][15], int'(VEC[i][14:7]));
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), VEC[i][6:5], VEC[i][4]);
    end

    // R4 repeated one-cycle mid glitches while LOW
    for (int k = 0; k < 30; k++) begin
      drive(1'b0, 1'b0, 1);
      drive(1'b0, 1'b1, 1);
    end
    check("R4 glitch train", EL, 1'b0);
    drive(1'b0, 1'b0, 77);
    check("R4 edge after train", EL, 1'b0);
    drive(1'b0, 1'b0, 1);
    check("R3 after train", ET, 1'b1);

    // R6 direct HIGH to LOW
    drive(1'b1, 1'b0, 9);
    check("R5 to HIGH", EH, 1'b1);
    drive(1'b0, 1'b1, 8);
    check("R6 eight low", EH, 1'b0);
    drive(1'b0, 1'b1, 1);
    check("R6 direct HIGH to LOW", EL, 1'b1);

    // R1 reset during operation
    rst = 1'b1;
    drive(1'b0, 1'b1, 3);
    check("R1 mid-run reset", ET, 1'b0);
    rst = 1'b0;
    // R3 undriven input stays TRISTATE with no strobe
    drive(1'b0, 1'b0, 200);
    check("R3 floating input", ET, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule